// File: doc/BRIEF.md
# Register File with Pointer Pairs

This block is the working-register storage of a small 8-bit processor: thirty-two byte-wide registers with two combinational byte read ports and one combinational 16-bit pair read port. It also has a byte write port and a 16-bit pair write port. Any read and write-back both fit in one clock cycle. Reads show the registered contents, so a value written in a cycle becomes visible on the following cycle.

The six highest registers form three 16-bit address pointers: X (indices 26/27), Y (28/29) and Z (30/31), each with its low byte in the even register. An address-generation port selects one pointer and one mode and returns a 16-bit effective address in the same cycle. The modes are plain, post-increment, pre-decrement, and an unsigned 6-bit displacement on Y or Z. The two stepping modes also write the stepped pointer back.

The register file also occupies data addresses 0x00 to 0x1F. When the effective address falls in that range, the register at that index can be read or written through a data-space byte port. A pointer can therefore address the file itself.

Top module: `ptr_regfile`

## Requirements
- R1: After reset every register reads 0x00.
- R2: The read ports `rd_a_data`, `rd_b_data` and `rw_data` are combinational views of the stored registers. A read of a register in the same cycle it is written returns the old value, and the new value appears after the clock edge.
- R3: With `wr_en` high, `wr_data` is stored into register `wr_idx` at the clock edge.
- R4: With `ww_en` high and `ww_idx` even, `ww_data[7:0]` goes to register `ww_idx` and `ww_data[15:8]` to register `ww_idx`+1. `rw_data` returns {register `rw_idx`|1, register `rw_idx`&~1}, so bit 0 of `rw_idx` is ignored.
- R5: A pair write with odd `ww_idx` raises `ww_err` in the same cycle and changes no register.
- R6: The `ag_sel` encoding is 0 for X (26/27), 1 for Y (28/29) and 2 for Z (30/31). Value 3 is reserved: it gives `ag_addr` = 0 and `ag_hit` = 0, and modifies no pointer.
- R7: When `ag_mode` is 1 (post-increment), `ag_addr` is the pointer value P and the pointer becomes P+1 at the edge, wrapping from 0xFFFF to 0x0000.
- R8: When `ag_mode` is 2 (pre-decrement), `ag_addr` is P-1 and the pointer becomes P-1 at the edge, wrapping from 0x0000 to 0xFFFF.
- R9: When `ag_mode` is 3 (displacement), `ag_addr` is P + `ag_disp` (unsigned, modulo 2^16) for Y and Z. For X the displacement is ignored and `ag_addr` is P. Mode 3 and mode 0 (plain, `ag_addr` = P) leave the pointer unchanged.
- R10: `ag_hit` is high when `ag_en` is high, the selection is valid and `ag_addr` < 0x20. On a hit, `ds_rdata` shows register `ag_addr` and `ds_we` writes `ds_wdata` into it. Without a hit, `ds_rdata` is 0x00 and `ds_we` has no effect.
- R11: Writes to different registers in the same cycle all take effect. When several writes target one register, the priority is pointer update first, then pair write, then data-space write, then byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| rw_idx | input | 5 | Pair read index (bit 0 ignored) |
| rw_data | output | 16 | Pair read data {odd, even} |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 5 | Byte write index |
| wr_data | input | 8 | Byte write data |
| ww_en | input | 1 | Pair write enable |
| ww_idx | input | 5 | Pair write base index (must be even) |
| ww_data | input | 16 | Pair write data |
| ww_err | output | 1 | Odd base on a pair write |
| ag_en | input | 1 | Address generation request |
| ag_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 reserved |
| ag_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| ag_disp | input | 6 | Unsigned displacement |
| ag_addr | output | 16 | Effective address |
| ag_hit | output | 1 | Effective address lies in the register window |
| ds_we | input | 1 | Data-space write through the effective address |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |

## Verification
Four write sources can land in one cycle: the pointer step, the pair write, the data-space store and the byte write. The bench aims them at the same register and also at different registers. For example, it post-increments X while a byte write targets register 26, and while a pair write targets 26/27. It also pairs a data-space store with a byte write to the same index. The winner is judged by reading the register back through the pair or byte read ports after the edge. In the disjoint case the bench confirms that both writes landed.

// File: rtl/ptr_regfile_pkg.sv
package ptr_regfile_pkg;

  typedef enum logic [1:0] {
    PM_PLAIN   = 2'd0,
    PM_POSTINC = 2'd1,
    PM_PREDEC  = 2'd2,
    PM_DISP    = 2'd3
  } ptr_mode_e;

  typedef enum logic [1:0] {
    PS_X    = 2'd0,
    PS_Y    = 2'd1,
    PS_Z    = 2'd2,
    PS_NONE = 2'd3
  } ptr_sel_e;

  localparam int PTR_COUNT = 3;

endpackage

// File: rtl/rf_ptr_agu.sv
module rf_ptr_agu
  import ptr_regfile_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DISP_W = 6,
  localparam int PW    = 2 * DW
) (
  input  logic              en,
  input  ptr_sel_e          sel,
  input  ptr_mode_e         mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [PW-1:0]     ptr_x,
  input  logic [PW-1:0]     ptr_y,
  input  logic [PW-1:0]     ptr_z,
  output logic              valid,
  output logic [PW-1:0]     cur,
  output logic [PW-1:0]     addr,
  output logic              upd,
  output logic [PW-1:0]     next_ptr
);

  function automatic logic [PW-1:0] eff_addr(input logic [PW-1:0] p,
                                             input ptr_mode_e m,
                                             input logic use_disp,
                                             input logic [DISP_W-1:0] d);
    case (m)
      PM_PREDEC: eff_addr = p - PW'(1);
      PM_DISP:   eff_addr = use_disp ? p + PW'(d) : p;
      default:   eff_addr = p;
    endcase
  endfunction

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p,
                                             input ptr_mode_e m);
    step_ptr = (m == PM_POSTINC) ? p + PW'(1) : p - PW'(1);
  endfunction

  always_comb begin
    case (sel)
      PS_X:    cur = ptr_x;
      PS_Y:    cur = ptr_y;
      PS_Z:    cur = ptr_z;
      default: cur = '0;
    endcase
  end

  assign valid    = en && (sel != PS_NONE);
  assign addr     = valid ? eff_addr(cur, mode, sel != PS_X, disp) : '0;
  assign upd      = valid && (mode == PM_POSTINC || mode == PM_PREDEC);
  assign next_ptr = step_ptr(cur, mode);

endmodule

// File: rtl/rf_window.sv
module rf_window #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int PW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic               valid,
  input  logic [PW-1:0]      addr,
  input  logic               we,
  input  logic [NREG*DW-1:0] regs_flat,
  output logic               hit,
  output logic [IW-1:0]      idx,
  output logic [DW-1:0]      rdata,
  output logic               wr_go
);

  assign hit   = valid && (addr < PW'(NREG));
  assign idx   = addr[IW-1:0];
  assign rdata = hit ? regs_flat[idx*DW +: DW] : '0;
  assign wr_go = we && hit;

endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pu_en,
  input  logic [IW-1:0]      pu_lo_idx,
  input  logic [2*DW-1:0]    pu_val,
  input  logic               ww_go,
  input  logic [IW-1:0]      ww_base,
  input  logic [2*DW-1:0]    ww_val,
  input  logic               dw_go,
  input  logic [IW-1:0]      dw_idx,
  input  logic [DW-1:0]      dw_val,
  input  logic               bw_en,
  input  logic [IW-1:0]      bw_idx,
  input  logic [DW-1:0]      bw_val,
  output logic [NREG*DW-1:0] regs_flat,
  output logic [NREG-1:0]    wr_hit_vec,
  output logic               bw_lost
);

  logic [NREG-1:0] upper_hit;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    logic          pu_lo, pu_hi, ww_lo, ww_hi, dw_hit, bw_hit;

    assign pu_lo  = pu_en && (pu_lo_idx == IW'(i));
    assign pu_hi  = pu_en && (pu_lo_idx + IW'(1) == IW'(i));
    assign ww_lo  = ww_go && (ww_base == IW'(i));
    assign ww_hi  = ww_go && (ww_base + IW'(1) == IW'(i));
    assign dw_hit = dw_go && (dw_idx == IW'(i));
    assign bw_hit = bw_en && (bw_idx == IW'(i));

    assign upper_hit[i]  = pu_lo || pu_hi || ww_lo || ww_hi || dw_hit;
    assign wr_hit_vec[i] = upper_hit[i] || bw_hit;

    always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (pu_lo)  q <= pu_val[DW-1:0];
      else if (pu_hi)  q <= pu_val[2*DW-1:DW];
      else if (ww_lo)  q <= ww_val[DW-1:0];
      else if (ww_hi)  q <= ww_val[2*DW-1:DW];
      else if (dw_hit) q <= dw_val;
      else if (bw_hit) q <= bw_val;
    end

    assign regs_flat[i*DW +: DW] = q;
  end

  assign bw_lost = bw_en && upper_hit[bw_idx];

endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptr_regfile_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int DW     = 8,
  parameter int DISP_W = 6,
  localparam int IW    = $clog2(NREG),
  localparam int PW    = 2 * DW,
  localparam int PBASE = NREG - 2 * PTR_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     rd_a_idx,
  output logic [DW-1:0]     rd_a_data,
  input  logic [IW-1:0]     rd_b_idx,
  output logic [DW-1:0]     rd_b_data,
  input  logic [IW-1:0]     rw_idx,
  output logic [PW-1:0]     rw_data,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              ww_en,
  input  logic [IW-1:0]     ww_idx,
  input  logic [PW-1:0]     ww_data,
  output logic              ww_err,
  input  logic              ag_en,
  input  logic [1:0]        ag_sel,
  input  logic [1:0]        ag_mode,
  input  logic [DISP_W-1:0] ag_disp,
  output logic [PW-1:0]     ag_addr,
  output logic              ag_hit,
  input  logic              ds_we,
  input  logic [DW-1:0]     ds_wdata,
  output logic [DW-1:0]     ds_rdata
);

  logic [NREG*DW-1:0] regs_flat;
  logic [NREG-1:0]    wr_hit_vec;
  logic               bw_lost;
  logic               ww_go;
  logic [IW-1:0]      rw_lo;
  logic [PW-1:0]      ptr_x, ptr_y, ptr_z;
  logic               ag_valid, ptr_upd;
  logic [PW-1:0]      ptr_cur, ptr_next;
  logic [IW-1:0]      ptr_lo_idx;
  logic [IW-1:0]      ds_idx;
  logic               ds_go;
  ptr_mode_e          mode_e;
  ptr_sel_e           sel_e;

  assign mode_e = ptr_mode_e'(ag_mode);
  assign sel_e  = ptr_sel_e'(ag_sel);

  assign ww_err = ww_en && ww_idx[0];
  assign ww_go  = ww_en && !ww_idx[0];

  assign rd_a_data = regs_flat[rd_a_idx*DW +: DW];
  assign rd_b_data = regs_flat[rd_b_idx*DW +: DW];
  assign rw_lo     = {rw_idx[IW-1:1], 1'b0};
  assign rw_data   = regs_flat[rw_lo*DW +: PW];

  assign ptr_x = regs_flat[(PBASE + 0)*DW +: PW];
  assign ptr_y = regs_flat[(PBASE + 2)*DW +: PW];
  assign ptr_z = regs_flat[(PBASE + 4)*DW +: PW];
  assign ptr_lo_idx = IW'(PBASE) + {ag_sel, 1'b0};

  rf_ptr_agu #(.DW(DW), .DISP_W(DISP_W)) u_agu (
    .en(ag_en), .sel(sel_e), .mode(mode_e), .disp(ag_disp),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .valid(ag_valid), .cur(ptr_cur), .addr(ag_addr),
    .upd(ptr_upd), .next_ptr(ptr_next)
  );

  rf_window #(.NREG(NREG), .DW(DW), .PW(PW)) u_win (
    .valid(ag_valid), .addr(ag_addr), .we(ds_we), .regs_flat(regs_flat),
    .hit(ag_hit), .idx(ds_idx), .rdata(ds_rdata), .wr_go(ds_go)
  );

  rf_store #(.NREG(NREG), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .pu_en(ptr_upd), .pu_lo_idx(ptr_lo_idx), .pu_val(ptr_next),
    .ww_go(ww_go), .ww_base(ww_idx), .ww_val(ww_data),
    .dw_go(ds_go), .dw_idx(ds_idx), .dw_val(ds_wdata),
    .bw_en(wr_en), .bw_idx(wr_idx), .bw_val(wr_data),
    .regs_flat(regs_flat), .wr_hit_vec(wr_hit_vec), .bw_lost(bw_lost)
  );

endmodule

// File: rtl/ptr_regfile_chk.sv
module ptr_regfile_chk #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NREG),
  localparam int PW  = 2 * DW
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NREG*DW-1:0] regs_flat,
  input logic [NREG-1:0]    wr_hit_vec,
  input logic               bw_lost,
  input logic               wr_en,
  input logic [IW-1:0]      wr_idx,
  input logic [DW-1:0]      wr_data,
  input logic               ww_go,
  input logic               ww_err,
  input logic [IW-1:0]      ww_idx,
  input logic [PW-1:0]      ww_data,
  input logic               ag_valid,
  input logic [1:0]         ag_mode,
  input logic [PW-1:0]      ag_addr,
  input logic               ptr_upd,
  input logic [PW-1:0]      ptr_cur,
  input logic [IW-1:0]      ptr_lo_idx
);

  function automatic logic [PW-1:0] pair_at(input logic [NREG*DW-1:0] f,
                                            input logic [IW-1:0] lo);
    pair_at = f[int'(lo)*DW +: PW];
  endfunction

  function automatic logic [DW-1:0] byte_at(input logic [NREG*DW-1:0] f,
                                            input logic [IW-1:0] i);
    byte_at = f[int'(i)*DW +: DW];
  endfunction

  assert_byte_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bw_lost) |=> byte_at(regs_flat, $past(wr_idx)) == $past(wr_data));

  assert_pair_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ww_go && !(ptr_upd && ptr_lo_idx == ww_idx))
      |=> pair_at(regs_flat, $past(ww_idx)) == $past(ww_data));

  assert_odd_pair_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ww_err |-> !ww_go);

  assert_postinc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_upd && ag_mode == 2'd1)
      |=> pair_at(regs_flat, $past(ptr_lo_idx)) == $past(ptr_cur) + PW'(1));

  assert_predec_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_upd && ag_mode == 2'd2)
      |=> pair_at(regs_flat, $past(ptr_lo_idx)) == $past(ag_addr));

  assert_disp_keeps_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ag_valid && ag_mode == 2'd3 && !wr_hit_vec[ptr_lo_idx]
       && !wr_hit_vec[ptr_lo_idx + IW'(1)])
      |=> pair_at(regs_flat, $past(ptr_lo_idx)) == $past(ptr_cur));

  assert_ptr_beats_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_upd && wr_en && wr_idx[IW-1:1] == ptr_lo_idx[IW-1:1]) |-> bw_lost);

endmodule

bind ptr_regfile ptr_regfile_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .regs_flat(regs_flat), .wr_hit_vec(wr_hit_vec),
  .bw_lost(bw_lost), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .ww_go(ww_go), .ww_err(ww_err), .ww_idx(ww_idx), .ww_data(ww_data),
  .ag_valid(ag_valid), .ag_mode(ag_mode), .ag_addr(ag_addr),
  .ptr_upd(ptr_upd), .ptr_cur(ptr_cur), .ptr_lo_idx(ptr_lo_idx)
);

// File: tb/ptr_regfile_bench.sv
module ptr_regfile_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {sel[2], mode[2], disp[6], init[16], exp_addr[16], exp_ptr[16]}
  localparam logic [57:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 6'd0,  16'h1234, 16'h1234, 16'h1234},
    {2'd0, 2'd1, 6'd0,  16'h1234, 16'h1234, 16'h1235},
    {2'd0, 2'd2, 6'd0,  16'h1234, 16'h1233, 16'h1233},
    {2'd0, 2'd3, 6'd5,  16'h1234, 16'h1234, 16'h1234},
    {2'd1, 2'd3, 6'h3F, 16'h1000, 16'h103F, 16'h1000},
    {2'd2, 2'd3, 6'd1,  16'hFFFF, 16'h0000, 16'hFFFF},
    {2'd2, 2'd1, 6'd0,  16'hFFFF, 16'hFFFF, 16'h0000},
    {2'd1, 2'd2, 6'd0,  16'h0000, 16'hFFFF, 16'hFFFF},
    {2'd2, 2'd0, 6'd9,  16'h00AB, 16'h00AB, 16'h00AB},
    {2'd1, 2'd1, 6'd0,  16'h0010, 16'h0010, 16'h0011}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] rd_a_idx, rd_b_idx, rw_idx, wr_idx, ww_idx;
  logic [7:0] rd_a_data, rd_b_data, wr_data, ds_wdata, ds_rdata;
  logic [15:0] rw_data, ww_data, ag_addr;
  logic wr_en, ww_en, ww_err, ag_en, ag_hit, ds_we;
  logic [1:0] ag_sel, ag_mode;
  logic [5:0] ag_disp;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_regfile u_ptr_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .rw_idx(rw_idx), .rw_data(rw_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ww_en(ww_en), .ww_idx(ww_idx), .ww_data(ww_data), .ww_err(ww_err),
    .ag_en(ag_en), .ag_sel(ag_sel), .ag_mode(ag_mode), .ag_disp(ag_disp),
    .ag_addr(ag_addr), .ag_hit(ag_hit),
    .ds_we(ds_we), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; ww_en = 0; ag_en = 0; ds_we = 0;
    wr_idx = '0; wr_data = '0; ww_idx = '0; ww_data = '0;
    ag_sel = '0; ag_mode = '0; ag_disp = '0; ds_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic put_pair(input logic [4:0] idx, input logic [15:0] v);
    ww_en = 1; ww_idx = idx; ww_data = v;
    step();
  endtask

  function automatic logic [15:0] pair_addr_of(input logic [1:0] sel);
    return 16'(26 + 2 * sel);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle();
    rd_a_idx = 0; rd_b_idx = 31; rw_idx = 26;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;

    // R1: reset state
    chk("R1 reg0", rd_a_data, 8'h00);
    chk("R1 reg31", rd_b_data, 8'h00);
    chk("R1 pair26", rw_data, 16'h0000);

    // Pointer mode table (R7 R8 R9 R6)
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] s, m;
      logic [5:0] d;
      logic [15:0] ini, ea, ep;
      {s, m, d, ini, ea, ep} = VEC[v];
      put_pair(5'(pair_addr_of(s)), ini);
      ag_en = 1; ag_sel = s; ag_mode = m; ag_disp = d;
      rw_idx = 5'(pair_addr_of(s));
      #1;
      chk("R7 R8 R9 vector addr", ag_addr, ea);
      chk("R10 vector hit", ag_hit, (ea < 16'h20));
      step();
      chk("R7 R8 R9 vector ptr", rw_data, ep);
    end

    // R2/R3: byte write, same-cycle read returns old value
    wr_en = 1; wr_idx = 5; wr_data = 8'hA5; rd_a_idx = 5;
    #1;
    chk("R2 read old", rd_a_data, 8'h00);
    step();
    chk("R3 byte write", rd_a_data, 8'hA5);
    wr_en = 1; wr_idx = 6; wr_data = 8'h3C;
    step();
    rd_b_idx = 6;
    #1;
    chk("R2 port A", rd_a_data, 8'hA5);
    chk("R2 port B", rd_b_data, 8'h3C);

    // R4: pair write and pair read ignoring bit 0
    put_pair(10, 16'hBEEF);
    rd_a_idx = 10; rd_b_idx = 11; rw_idx = 11;
    #1;
    chk("R4 low byte", rd_a_data, 8'hEF);
    chk("R4 high byte", rd_b_data, 8'hBE);
    chk("R4 pair read odd idx", rw_data, 16'hBEEF);

    // R5: odd pair write ignored
    ww_en = 1; ww_idx = 13; ww_data = 16'h1111;
    #1;
    chk("R5 err flag", ww_err, 1'b1);
    step();
    chk("R5 no err idle", ww_err, 1'b0);
    rd_a_idx = 13; rd_b_idx = 14; rw_idx = 12;
    #1;
    chk("R5 reg13", rd_a_data, 8'h00);
    chk("R5 reg14", rd_b_data, 8'h00);
    chk("R5 reg12", rw_data[7:0], 8'h00);

    // R6: reserved select
    put_pair(30, 16'h0003);
    ag_en = 1; ag_sel = 3; ag_mode = 1;
    #1;
    chk("R6 addr", ag_addr, 16'h0000);
    chk("R6 hit", ag_hit, 1'b0);
    step();
    rw_idx = 30;
    #1;
    chk("R6 Z untouched", rw_data, 16'h0003);

    // R10: window read and write through Z
    put_pair(30, 16'h0005);
    ag_en = 1; ag_sel = 2; ag_mode = 0;
    #1;
    chk("R10 hit", ag_hit, 1'b1);
    chk("R10 rdata", ds_rdata, 8'hA5);
    ds_we = 1; ds_wdata = 8'h77;
    step();
    rd_a_idx = 5;
    #1;
    chk("R10 store", rd_a_data, 8'h77);
    put_pair(30, 16'h0020);
    ag_en = 1; ag_sel = 2; ag_mode = 0; ds_we = 1; ds_wdata = 8'h99;
    #1;
    chk("R10 miss hit", ag_hit, 1'b0);
    chk("R10 miss rdata", ds_rdata, 8'h00);
    step();
    rd_a_idx = 0;
    #1;
    chk("R10 miss ignored", rd_a_data, 8'h00);

    // R11: pointer update beats byte write on same register
    put_pair(26, 16'h0040);
    ag_en = 1; ag_sel = 0; ag_mode = 1;
    wr_en = 1; wr_idx = 26; wr_data = 8'hEE;
    step();
    rw_idx = 26;
    #1;
    chk("R11 ptr over byte", rw_data, 16'h0041);

    // R11: different registers both land
    ag_en = 1; ag_sel = 0; ag_mode = 1;
    wr_en = 1; wr_idx = 3; wr_data = 8'h33;
    step();
    rd_a_idx = 3;
    #1;
    chk("R11 disjoint ptr", rw_data, 16'h0042);
    chk("R11 disjoint byte", rd_a_data, 8'h33);

    // R11: pointer update beats pair write
    ag_en = 1; ag_sel = 0; ag_mode = 1;
    ww_en = 1; ww_idx = 26; ww_data = 16'h9999;
    step();
    chk("R11 ptr over pair", rw_data, 16'h0043);

    // R11: pair write beats byte write
    ww_en = 1; ww_idx = 8; ww_data = 16'h2222;
    wr_en = 1; wr_idx = 8; wr_data = 8'h55;
    step();
    rd_a_idx = 8;
    #1;
    chk("R11 pair over byte", rd_a_data, 8'h22);

    // R11: data-space store beats byte write
    put_pair(30, 16'h0005);
    ag_en = 1; ag_sel = 2; ag_mode = 0; ds_we = 1; ds_wdata = 8'h44;
    wr_en = 1; wr_idx = 5; wr_data = 8'h66;
    step();
    rd_a_idx = 5;
    #1;
    chk("R11 store over byte", rd_a_data, 8'h44);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule